// File: doc/BRIEF.md
# Divide Cycle Count Calculator

This block predicts how many clock cycles a classic microcoded 16-bit-divisor processor spends on its divide instruction when the source operand is a register. It takes a 32-bit dividend, a 16-bit divisor and a mode bit that selects unsigned or signed division. It returns the cycle count that processor would take. It does not return the quotient. A cycle-accurate system model uses it to charge the right number of cycles for each divide it executes.

The block works one step per clock. A shared shift-subtract datapath runs the divide loop. In unsigned mode the loop itself sets the count. In signed mode the same loop produces the 16-bit magnitude of the quotient, and each zero quotient bit adds to the count. Division by zero and overflow of the upper half are known at once, so these cases finish in a single cycle. Each result is announced with a one-cycle `done` pulse and then held on `count` until the next result.

Top module: `dcc_divcycles`

## Requirements
- R1: A divisor of zero gives a count of 0 in either mode.
- R2: In unsigned mode, when dividend[31:16] >= divisor (divisor nonzero), the count is 10.
- R3: In unsigned mode without the early exit, an accumulator starts at 38 and the block runs 15 steps. Each step shifts the dividend left by one. If the bit shifted out was 1, it subtracts divisor<<16 (mod 2^32) and adds nothing. Otherwise it adds 2, and if the shifted dividend is >= divisor<<16 it subtracts that value and takes 1 back off. The count is twice the final accumulator.
- R4: In signed mode (two's complement operands), let |a| and |b| be the magnitudes of the dividend and divisor. When |a|>>16 >= |b|, the count is 16 for a non-negative dividend and 18 for a negative one.
- R5: Otherwise in signed mode the half-count is the sum of these terms, and the count is twice the sum:
  - 61;
  - 1 more when the dividend is negative;
  - when the divisor is non-negative, a further +1 for a negative dividend or -1 for a non-negative one;
  - one for each zero among bits 15..1 of the 16-bit quotient |a|/|b|.
- R6: Every nonzero count is even. Unsigned loop counts lie in 76..136 and signed loop counts in 120..156.
- R7: The accept edge is the clock edge at which `start` is sampled while idle. After a zero-divisor or early exit, `done` is high in the cycle right after the accept edge and `busy` stays low. For an unsigned loop, `busy` is high for 15 cycles and `done` follows 15 edges after the accept edge. For a signed loop, `busy` is high for 16 cycles and `done` follows 16 edges after.
- R8: `done` is high for one cycle per result and never together with `busy`. `count` changes only in a cycle where `done` is high and holds its value otherwise.
- R9: `start` while `busy` is high is ignored. It does not change the running operation, its timing or its result.
- R10: While `rstN` is low, `busy`, `done` and `count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request; accepted only while idle |
| signedMode | input | 1 | 1 = signed divide, 0 = unsigned |
| dividend | input | 32 | Dividend, sampled at accept |
| divisor | input | 16 | Divisor, sampled at accept |
| busy | output | 1 | Loop in progress |
| done | output | 1 | One-cycle result strobe |
| count | output | 8 | Cycle count of the last finished request |

## Verification
If the working register or the accumulator goes wrong, the damage first shows at the `done` pulse that ends the operation. It appears there as an odd count, a count off by a few cycles, or a count outside the mode's range. A step counter or limit that goes wrong shows up earlier: `done` arrives one or more cycles early or late, or `busy` does not match the request's mode. A per-clock comparison against a behavioural model catches both kinds of fault at the first cycle where the ports differ.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ctrlState_t;

  typedef struct packed {
    logic load;
    logic step;
    logic last;
  } dpStrobe_t;

  localparam int UNS_BASE      = 38;
  localparam int UNS_OVF_HALF  = 5;
  localparam int SGN_BASE      = 6;
  localparam int SGN_OVF_EXTRA = 2;
  localparam int SGN_BODY      = 55;

endpackage

// File: rtl/dcc_control.sv
module dcc_control
  import dcc_pkg::*;
#(
  parameter int DIVISOR_W = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      signedMode,
  input  logic      quickExit,
  output dpStrobe_t strobe,
  output logic      busy,
  output logic      done
);

  localparam int UNS_STEPS = DIVISOR_W - 1;
  localparam int SGN_STEPS = DIVISOR_W;
  localparam int STEP_W    = $clog2(SGN_STEPS + 1);

  ctrlState_t  state;
  logic [STEP_W-1:0] stepCnt;
  logic [STEP_W-1:0] stepLim;
  logic              doneReg;
  logic              isLast;

  assign isLast = (state == ST_RUN) && (stepCnt == stepLim - STEP_W'(1));

  always_comb begin
    strobe.load = (state == ST_IDLE) && start;
    strobe.step = (state == ST_RUN);
    strobe.last = isLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      stepLim <= '0;
      doneReg <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (quickExit) begin
              doneReg <= 1'b1;
            end else begin
              state   <= ST_RUN;
              stepCnt <= '0;
              stepLim <= signedMode ? STEP_W'(SGN_STEPS) : STEP_W'(UNS_STEPS);
            end
          end
        end
        ST_RUN: begin
          stepCnt <= stepCnt + STEP_W'(1);
          if (isLast) begin
            state   <= ST_IDLE;
            doneReg <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state == ST_RUN);
  assign done = doneReg;

endmodule

// File: rtl/dcc_datapath.sv
module dcc_datapath
  import dcc_pkg::*;
#(
  parameter int DIVISOR_W = 16,
  parameter int CNT_W     = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStrobe_t              strobe,
  input  logic                   signedMode,
  input  logic [2*DIVISOR_W-1:0] dividend,
  input  logic [DIVISOR_W-1:0]   divisor,
  output logic                   quickExit,
  output logic [CNT_W-1:0]       count
);

  localparam int DVD_W = 2 * DIVISOR_W;

  // load-time decode
  logic             dvdNeg;
  logic             dvsNeg;
  logic [DVD_W-1:0] absDvd;
  logic [DIVISOR_W-1:0] absDvs;
  logic             dvsZero;
  logic             hiOverflow;
  logic [CNT_W-1:0] quickHalf;
  logic [CNT_W-1:0] loopStart;

  assign dvdNeg     = signedMode & dividend[DVD_W-1];
  assign dvsNeg     = signedMode & divisor[DIVISOR_W-1];
  assign absDvd     = dvdNeg ? (~dividend + DVD_W'(1)) : dividend;
  assign absDvs     = dvsNeg ? (~divisor + DIVISOR_W'(1)) : divisor;
  assign dvsZero    = (divisor == '0);
  assign hiOverflow = (absDvd[DVD_W-1:DIVISOR_W] >= absDvs);
  assign quickExit  = dvsZero | hiOverflow;

  always_comb begin
    if (dvsZero)
      quickHalf = '0;
    else if (signedMode)
      quickHalf = CNT_W'(SGN_BASE + SGN_OVF_EXTRA) + CNT_W'(dvdNeg);
    else
      quickHalf = CNT_W'(UNS_OVF_HALF);
  end

  always_comb begin
    if (!signedMode)
      loopStart = CNT_W'(UNS_BASE);
    else if (dvsNeg)
      loopStart = CNT_W'(SGN_BASE + SGN_BODY) + CNT_W'(dvdNeg);
    else if (dvdNeg)
      loopStart = CNT_W'(SGN_BASE + SGN_BODY + 2);
    else
      loopStart = CNT_W'(SGN_BASE + SGN_BODY - 1);
  end

  // shared shift-subtract step
  logic [DVD_W-1:0]     work;
  logic [DIVISOR_W-1:0] dvsReg;
  logic                 modeReg;
  logic [CNT_W-1:0]     acc;
  logic [CNT_W-1:0]     countReg;

  logic                 carryOut;
  logic [DVD_W-1:0]     shifted;
  logic [DIVISOR_W-1:0] hiShift;
  logic                 qBit;
  logic [DIVISOR_W-1:0] hiNext;
  logic [DVD_W-1:0]     workNext;
  logic [1:0]           accInc;
  logic [CNT_W-1:0]     accNext;

  assign carryOut = work[DVD_W-1];
  assign shifted  = {work[DVD_W-2:0], 1'b0};
  assign hiShift  = shifted[DVD_W-1:DIVISOR_W];
  assign qBit     = carryOut | (hiShift >= dvsReg);
  assign hiNext   = qBit ? (hiShift - dvsReg) : hiShift;
  assign workNext = {hiNext, shifted[DIVISOR_W-1:0]};

  always_comb begin
    if (modeReg)
      accInc = (!qBit && !strobe.last) ? 2'd1 : 2'd0;
    else if (carryOut)
      accInc = 2'd0;
    else
      accInc = qBit ? 2'd1 : 2'd2;
  end

  assign accNext = acc + CNT_W'(accInc);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      work     <= '0;
      dvsReg   <= '0;
      modeReg  <= 1'b0;
      acc      <= '0;
      countReg <= '0;
    end else if (strobe.load) begin
      work    <= absDvd;
      dvsReg  <= absDvs;
      modeReg <= signedMode;
      acc     <= loopStart;
      if (quickExit)
        countReg <= {quickHalf[CNT_W-2:0], 1'b0};
    end else if (strobe.step) begin
      work <= workNext;
      acc  <= accNext;
      if (strobe.last)
        countReg <= {accNext[CNT_W-2:0], 1'b0};
    end
  end

  assign count = countReg;

endmodule

// File: rtl/dcc_divcycles.sv
module dcc_divcycles
  import dcc_pkg::*;
#(
  parameter int DIVISOR_W = 16,
  parameter int CNT_W     = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic                   signedMode,
  input  logic [2*DIVISOR_W-1:0] dividend,
  input  logic [DIVISOR_W-1:0]   divisor,
  output logic                   busy,
  output logic                   done,
  output logic [CNT_W-1:0]       count
);

  dpStrobe_t strobe;
  logic      quickExit;

  dcc_control #(.DIVISOR_W(DIVISOR_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .signedMode (signedMode),
    .quickExit  (quickExit),
    .strobe     (strobe),
    .busy       (busy),
    .done       (done)
  );

  dcc_datapath #(.DIVISOR_W(DIVISOR_W), .CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .signedMode (signedMode),
    .dividend   (dividend),
    .divisor    (divisor),
    .quickExit  (quickExit),
    .count      (count)
  );

endmodule

// File: rtl/dcc_divcycles_chk.sv
module dcc_divcycles_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] count
);

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_count_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(count));

  assert_count_even_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !count[0]);

  assert_count_ceiling_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (count <= CNT_W'(156)));

  assert_busy_needs_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

endmodule

bind dcc_divcycles dcc_divcycles_chk #(.CNT_W(CNT_W)) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .busy  (busy),
  .done  (done),
  .count (count)
);

// File: tb/test_dcc_divcycles.sv
module test_dcc_divcycles;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        signedMode = 1'b0;
  logic [31:0] dividend = '0;
  logic [15:0] divisor = '0;
  logic        busy;
  logic        done;
  logic [7:0]  count;

  int total = 0;
  int bad = 0;
  int cycleNo = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcc_divcycles i_dcc_divcycles (
    .clk(clk), .rstN(rstN), .start(start), .signedMode(signedMode),
    .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .count(count)
  );

  // behavioural reference of the count
  function automatic int refCount(bit sgn, bit [31:0] a, bit [15:0] b);
    int acc;
    bit [31:0] d;
    bit [31:0] h;
    bit top;
    longint sa;
    longint ua;
    int sb;
    int ub;
    int q;
    if (b == 0) return 0;
    if (!sgn) begin
      if (a[31:16] >= b) return 10;
      acc = 38;
      d = a;
      h = {b, 16'h0};
      for (int i = 0; i < 15; i++) begin
        top = d[31];
        d = d << 1;
        if (top) d = d - h;
        else begin
          acc += 2;
          if (d >= h) begin d = d - h; acc -= 1; end
        end
      end
      return acc * 2;
    end
    sa = longint'($signed(a));
    sb = int'($signed(b));
    acc = 6;
    if (sa < 0) acc++;
    ua = (sa < 0) ? -sa : sa;
    ub = (sb < 0) ? -sb : sb;
    if ((ua >> 16) >= longint'(ub)) return (acc + 2) * 2;
    q = int'(ua / longint'(ub));
    acc += 55;
    if (sb >= 0) acc += (sa < 0) ? 1 : -1;
    for (int i = 15; i >= 1; i--) if (!q[i]) acc++;
    return acc * 2;
  endfunction

  function automatic string refTag(bit sgn, bit [31:0] a, bit [15:0] b);
    longint sa;
    int sb;
    longint ua;
    int ub;
    if (b == 0) return "R1";
    if (!sgn) return (a[31:16] >= b) ? "R2" : "R3";
    sa = longint'($signed(a));
    sb = int'($signed(b));
    ua = (sa < 0) ? -sa : sa;
    ub = (sb < 0) ? -sb : sb;
    return ((ua >> 16) >= longint'(ub)) ? "R4" : "R5";
  endfunction

  // cycle model
  logic  mBusy = 0;
  logic  mDone = 0;
  logic [7:0] mCount = 0;
  int    mRemain = 0;
  int    mPending = 0;
  string mTag = "R10";
  string mPendTag = "R10";

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy <= 0; mDone <= 0; mCount <= 0; mRemain <= 0; mTag <= "R10";
    end else begin
      mDone <= 0;
      if (mRemain > 0) begin
        if (mRemain == 1) begin
          mBusy <= 0; mDone <= 1; mCount <= 8'(mPending); mTag <= mPendTag;
        end
        mRemain <= mRemain - 1;
      end else if (start) begin
        if (refTag(signedMode, dividend, divisor) inside {"R1", "R2", "R4"}) begin
          mDone  <= 1;
          mCount <= 8'(refCount(signedMode, dividend, divisor));
          mTag   <= refTag(signedMode, dividend, divisor);
        end else begin
          mBusy    <= 1;
          mRemain  <= signedMode ? 16 : 15;
          mPending <= refCount(signedMode, dividend, divisor);
          mPendTag <= refTag(signedMode, dividend, divisor);
        end
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cycleNo);
    end
  endtask

  always @(negedge clk) begin
    cycleNo++;
    if (rstN && !finished) begin
      check(busy == mBusy, "R7", busy, mBusy);
      check(done == mDone, "R7", done, mDone);
      if (mDone) check(count == mCount, mTag, count, mCount);
      else       check(count == mCount, "R8", count, mCount);
    end
  end

  task automatic runOp(bit sgn, bit [31:0] a, bit [15:0] b, int expVal, string req);
    int waited;
    @(negedge clk);
    start = 1; signedMode = sgn; dividend = a; divisor = b;
    @(negedge clk);
    start = 0;
    waited = 0;
    while (!done && waited < 40) begin @(negedge clk); waited++; end
    check(done == 1'b1, req, done, 1);
    if (expVal >= 0) check(count == 8'(expVal), req, count, expVal);
    if (count != 0) begin
      check(count[0] == 1'b0, "R6", count, count & 8'hFE);
      if (refTag(sgn, a, b) == "R3")
        check(count >= 76 && count <= 136, "R6", count, 76);
      if (refTag(sgn, a, b) == "R5")
        check(count >= 120 && count <= 156, "R6", count, 120);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    check(1'b0, "watchdog", cycleNo, WATCHDOG);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0, "R10", busy, 0);
    check(done == 0, "R10", done, 0);
    check(count == 0, "R10", count, 0);
    @(negedge clk);
    rstN = 1;
    @(negedge clk);

    runOp(0, 32'h1234_5678, 16'h0000, 0, "R1");
    runOp(1, 32'h8000_0000, 16'h0000, 0, "R1");
    runOp(0, 32'h0005_0000, 16'h0005, 10, "R2");
    runOp(0, 32'hFFFF_FFFF, 16'h0001, 10, "R2");
    runOp(0, 32'h0000_0000, 16'h0001, 136, "R3");
    runOp(0, 32'h0000_0064, 16'h0007, -1, "R3");
    runOp(0, 32'h0004_FFFF, 16'h0005, -1, "R3");
    runOp(0, 32'h1234_5678, 16'hFFFF, -1, "R3");
    runOp(1, 32'h8000_0000, 16'h0001, 18, "R4");
    runOp(1, 32'h0005_0000, 16'h0003, 16, "R4");
    runOp(1, 32'h0000_0000, 16'h0001, 150, "R5");
    runOp(1, 32'hFFFF_FFF9, 16'hFFFE, 152, "R5");
    runOp(1, 32'h0000_03E8, 16'h8000, -1, "R5");
    runOp(1, 32'h7FFF_FFFF, 16'h7FFF, -1, "R4");

    // R9: a second start during a running loop is ignored
    @(negedge clk);
    start = 1; signedMode = 0; dividend = 32'h0; divisor = 16'h0001;
    @(negedge clk);
    start = 0;
    repeat (3) @(negedge clk);
    start = 1; signedMode = 0; dividend = 32'h0; divisor = 16'h0000;
    @(negedge clk);
    start = 0;
    check(done == 0, "R9", done, 0);
    while (!done) @(negedge clk);
    check(count == 8'd136, "R9", count, 136);

    // R7: back-to-back quick exits accepted on consecutive edges
    @(negedge clk);
    start = 1; signedMode = 0; dividend = 32'h0009_0000; divisor = 16'h0002;
    @(negedge clk);
    check(done == 1 && count == 8'd10, "R7", count, 10);
    signedMode = 1; dividend = 32'hFFF0_0000; divisor = 16'h0001;
    @(negedge clk);
    start = 0;
    check(done == 1 && count == 8'd18, "R7", count, 18);

    for (int k = 0; k < 60; k++) begin
      bit [31:0] a;
      bit [15:0] b;
      a = $urandom;
      b = 16'($urandom);
      if (k % 2 == 0) a = {16'($urandom % 32'h100), a[15:0]};
      runOp(k % 3 == 0, a, b, -1, "R6");
    end

    repeat (4) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule